// File: doc/BRIEF.md
# Partial-Word Load/Store Byte Merge Unit

This unit performs the byte-lane merge behind the two-sided partial-word loads and stores of a little-endian processor. A request carries an operation code, an effective byte address, the register operand and a destination register index. The unit reads the word-aligned memory word that holds the addressed byte. The two low address bits then pick which bytes of the result come from memory and which from the register operand.

A load finishes with a one-cycle done pulse. The pulse carries the merged register value and the destination index. A store is a read-modify-write: after the read returns, the merged word is written back to the same aligned address, and done follows.

A load may target a register whose earlier load is still waiting in the processor's delay stage. In that case the caller presents the pending value on a forwarding port, and the unit merges against that value instead of the stale register-file value. Partial accesses never fault on alignment. The lane count, address width and register index width are parameters.

Top module: `upw_merge`

## Requirements
- R1: Every memory read and write uses the request address with its low log2(LANES) bits cleared. Any address, including one not aligned to a word, is accepted without a fault.
- R2: High-side load (`req_op` = 2'b00) at byte offset k: the lanes from 3-k upward receive memory bytes starting from byte 0. The lower lanes keep the operand. With k=0 the result is operand[23:0] under mem[7:0]<<24; k=1 gives mem<<16 over operand[15:0]; k=2 gives mem<<8 over operand[7:0]; k=3 gives the whole memory word.
- R3: Low-side load (`req_op` = 2'b01) at offset k: the result is mem>>(8k), with the top k bytes kept from the operand. With k=0 the result is the whole memory word.
- R4: High-side store (`req_op` = 2'b10) at offset k: the written word is operand>>(8*(3-k)) in the low k+1 bytes, with the remaining upper bytes of memory kept. With k=3 the whole operand is written.
- R5: Low-side store (`req_op` = 2'b11) at offset k: the written word is operand<<(8k), with the low k bytes of memory kept. With k=0 the whole operand is written.
- R6: For loads only, when `fwd_valid` is high and `fwd_idx` equals `req_dest`, `fwd_data` replaces `req_reg_data` as the operand. Stores, mismatched indices and `fwd_valid` low all use `req_reg_data`.
- R7: A store raises `mem_rd_en` for one cycle and waits for `mem_rvalid`. In the cycle after `mem_rvalid` it raises `mem_wr_en` for one cycle with the merged word, and it pulses `done` in the cycle after the write.
- R8: A load pulses `done` for one cycle, in the cycle after `mem_rvalid`, with `done_data` and `done_dest`. A load never raises `mem_wr_en`.
- R9: `req_ready` is low from acceptance until `done`. A `req_valid` presented while busy has no effect: no extra read, and the result is unchanged.
- R10: After reset `req_ready` is high and `mem_rd_en`, `mem_wr_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| req_op | input | 2 | bit1: store, bit0: low side |
| req_addr | input | AW | Effective byte address |
| req_reg_data | input | 8*LANES | Register operand from the register file |
| req_dest | input | RIW | Destination register index (loads) |
| fwd_valid | input | 1 | A delayed load is pending |
| fwd_idx | input | RIW | Register index of the pending load |
| fwd_data | input | 8*LANES | Value of the pending load |
| mem_rd_en | output | 1 | Read strobe, one cycle |
| mem_wr_en | output | 1 | Write strobe, one cycle |
| mem_addr | output | AW | Aligned word address |
| mem_wdata | output | 8*LANES | Merged store word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8*LANES | Aligned memory word |
| done | output | 1 | Operation complete, one cycle |
| done_dest | output | RIW | Destination index of the completed operation |
| done_data | output | 8*LANES | Merged value (load result or stored word) |

## Verification
On every cycle the assertions check the protocol shape of the unit. Memory strobes carry aligned addresses, a write is always preceded by read data, and the done pulse lasts one cycle. Ready stays low while a read is in flight, the forwarded operand is the one captured, and the two full-word offsets pass their source through unchanged.

Only the bench's scenarios can show the partial byte patterns of all four merge rules at every offset. They also show that a request offered while the unit is busy changes nothing, and that a stored word reaches memory and is seen by a later load.

// File: rtl/upw_pkg.sv
package upw_pkg;
   // bit1 selects store, bit0 selects the low-side merge
   typedef enum logic [1:0] {
      UPW_LD_HI = 2'b00,
      UPW_LD_LO = 2'b01,
      UPW_ST_HI = 2'b10,
      UPW_ST_LO = 2'b11
   } upw_op_e;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_WAIT  = 2'd2,
      SEQ_WRITE = 2'd3
   } upw_state_e;
endpackage

// File: rtl/upw_byte_merge.sv
module upw_byte_merge
   import upw_pkg::*;
#(
   parameter int LANES = 4,
   localparam int DW = 8 * LANES,
   localparam int OW = $clog2(LANES)
) (
   input  upw_op_e          op,
   input  logic [OW-1:0]    off,
   input  logic [DW-1:0]    opnd_word,
   input  logic [DW-1:0]    mem_word,
   output logic [DW-1:0]    merged
);
   localparam logic [OW-1:0] LAST = OW'(LANES - 1);
   localparam logic [OW:0]   TOPW = (OW+1)'(LANES - 1);

   logic [7:0] opnd_b [LANES];
   logic [7:0] mem_b  [LANES];

   for (genvar b = 0; b < LANES; b++) begin : g_split
      assign opnd_b[b] = opnd_word[8*b +: 8];
      assign mem_b[b]  = mem_word[8*b +: 8];
   end

   // each output lane picks one source byte; offset sets the shift
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam logic [OW-1:0] JJ = OW'(j);
      logic          take_mem;
      logic [OW-1:0] idx;
      logic [OW-1:0] span;

      always_comb begin
         take_mem = 1'b0;
         idx      = JJ;
         span     = LAST - off;
         unique case (op)
            UPW_LD_HI: if (JJ >= span) begin
               take_mem = 1'b1;
               idx      = JJ - span;
            end
            UPW_LD_LO: if (({1'b0, JJ} + {1'b0, off}) <= TOPW) begin
               take_mem = 1'b1;
               idx      = JJ + off;
            end
            UPW_ST_HI: if (JJ <= off) idx = JJ + span;
                       else           take_mem = 1'b1;
            UPW_ST_LO: if (JJ >= off) idx = JJ - off;
                       else           take_mem = 1'b1;
            default: ;
         endcase
      end

      assign merged[8*j +: 8] = take_mem ? mem_b[idx] : opnd_b[idx];
   end
endmodule

// File: rtl/upw_seq.sv
module upw_seq
   import upw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_store,
   input  logic rvalid,
   output logic ready,
   output logic rd_en,
   output logic wr_en,
   output logic capture,
   output logic done
);
   upw_state_e state, state_nx;

   assign ready   = (state == SEQ_IDLE);
   assign rd_en   = (state == SEQ_READ);
   assign wr_en   = (state == SEQ_WRITE);
   assign capture = (state == SEQ_WAIT) && rvalid;

   always_comb begin
      state_nx = state;
      unique case (state)
         SEQ_IDLE:  if (start) state_nx = SEQ_READ;
         SEQ_READ:  state_nx = SEQ_WAIT;
         SEQ_WAIT:  if (rvalid) state_nx = is_store ? SEQ_WRITE : SEQ_IDLE;
         SEQ_WRITE: state_nx = SEQ_IDLE;
         default:   state_nx = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         done  <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= (capture && !is_store) || wr_en;
      end
   end

   // R7
   wr_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(capture));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/upw_merge.sv
module upw_merge
   import upw_pkg::*;
#(
   parameter int LANES = 4,
   parameter int AW    = 32,
   parameter int RIW   = 5,
   localparam int DW   = 8 * LANES,
   localparam int OW   = $clog2(LANES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [1:0]      req_op,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_reg_data,
   input  logic [RIW-1:0]  req_dest,
   input  logic            fwd_valid,
   input  logic [RIW-1:0]  fwd_idx,
   input  logic [DW-1:0]   fwd_data,
   output logic            mem_rd_en,
   output logic            mem_wr_en,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic            mem_rvalid,
   input  logic [DW-1:0]   mem_rdata,
   output logic            done,
   output logic [RIW-1:0]  done_dest,
   output logic [DW-1:0]   done_data
);
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (AW <= OW) begin : g_bad_aw
      $error("AW must exceed the lane offset width");
   end
   if (RIW < 1) begin : g_bad_riw
      $error("RIW must be at least 1");
   end

   upw_op_e          op_q;
   logic [OW-1:0]    off_q;
   logic [AW-OW-1:0] base_q;
   logic [RIW-1:0]   dest_q;
   logic [DW-1:0]    opnd_q;
   logic [DW-1:0]    res_q;
   logic [DW-1:0]    merged;
   logic             accept, capture, use_fwd;

   assign accept  = req_valid && req_ready;
   assign use_fwd = !req_op[1] && fwd_valid && (fwd_idx == req_dest);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= UPW_LD_HI;
         off_q  <= '0;
         base_q <= '0;
         dest_q <= '0;
         opnd_q <= '0;
         res_q  <= '0;
      end else begin
         if (accept) begin
            op_q   <= upw_op_e'(req_op);
            off_q  <= req_addr[OW-1:0];
            base_q <= req_addr[AW-1:OW];
            dest_q <= req_dest;
            opnd_q <= use_fwd ? fwd_data : req_reg_data;
         end
         if (capture) res_q <= merged;
      end
   end

   upw_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .is_store (op_q[1]),
      .rvalid   (mem_rvalid),
      .ready    (req_ready),
      .rd_en    (mem_rd_en),
      .wr_en    (mem_wr_en),
      .capture  (capture),
      .done     (done)
   );

   upw_byte_merge #(.LANES(LANES)) u_merge (
      .op        (op_q),
      .off       (off_q),
      .opnd_word (opnd_q),
      .mem_word  (mem_rdata),
      .merged    (merged)
   );

   assign mem_addr  = {base_q, {OW{1'b0}}};
   assign mem_wdata = res_q;
   assign done_data = res_q;
   assign done_dest = dest_q;

   // R1
   aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en || mem_wr_en) |-> (mem_addr[OW-1:0] == '0));

   // R7
   wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> done);

   // R9
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en || mem_wr_en) |-> !req_ready);

   // R6
   fwd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && use_fwd) |=> (opnd_q == $past(fwd_data)));

   // R2
   ld_hi_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && op_q == UPW_LD_HI && off_q == OW'(LANES - 1))
      |=> (res_q == $past(mem_rdata)));

   // R5
   st_lo_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && op_q == UPW_ST_LO && off_q == '0) |=> (res_q == opnd_q));
endmodule

// File: tb/upw_merge_bench.sv
`timescale 1ns/1ps
module upw_merge_bench;
   localparam int AW = 8;
   localparam int RIW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [1:0] req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0] req_reg_data = '0;
   logic [RIW-1:0] req_dest = '0;
   logic fwd_valid = 1'b0;
   logic [RIW-1:0] fwd_idx = '0;
   logic [31:0] fwd_data = '0;
   logic mem_rd_en, mem_wr_en;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic done;
   logic [RIW-1:0] done_dest;
   logic [31:0] done_data;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] mem_w [64];

   always #2 clk = ~clk;

   upw_merge #(.LANES(4), .AW(AW), .RIW(RIW)) u_upw_merge (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_reg_data(req_reg_data), .req_dest(req_dest),
      .fwd_valid(fwd_valid), .fwd_idx(fwd_idx), .fwd_data(fwd_data),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .done(done), .done_dest(done_dest), .done_data(done_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic logic [31:0] exp_merge(input logic [1:0] op, input int k,
                                            input logic [31:0] r, input logic [31:0] m);
      logic [31:0] ones = 32'hFFFF_FFFF;
      case (op)
         2'b00: return (k == 3) ? m : ((r & (ones >> (8*(k+1)))) | (m << (8*(3-k))));
         2'b01: return (k == 0) ? m : ((r & ~(ones >> (8*k))) | (m >> (8*k)));
         2'b10: return (k == 3) ? r : ((m & ~(ones >> (8*(3-k)))) | (r >> (8*(3-k))));
         default: return (k == 0) ? r : ((m & (ones >> (8*(4-k)))) | (r << (8*k)));
      endcase
   endfunction

   function automatic string op_req(input logic [1:0] op);
      case (op)
         2'b00: return "R2";
         2'b01: return "R3";
         2'b10: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic run_op(input logic [1:0] op, input logic [AW-1:0] addr,
                         input logic [31:0] regv, input logic [RIW-1:0] dest,
                         input bit fv, input logic [RIW-1:0] fidx,
                         input logic [31:0] fdata, input int lat, input bit poke);
      logic [31:0] opnd, memv, exp;
      logic [AW-1:0] wa;
      int k;
      wa = addr & ~AW'(3);
      k = int'(addr[1:0]);
      opnd = (!op[1] && fv && fidx == dest) ? fdata : regv;
      memv = mem_w[addr[7:2]];
      exp = exp_merge(op, k, opnd, memv);
      @(negedge clk);
      chk(req_ready == 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_op = op; req_addr = addr; req_reg_data = regv;
      req_dest = dest; fwd_valid = fv; fwd_idx = fidx; fwd_data = fdata;
      @(negedge clk);
      req_valid = 1'b0; fwd_valid = 1'b0;
      fwd_data = 32'hDEAD_BEEF; req_reg_data = 32'hBAD0_BAD0;
      chk(mem_rd_en == 1'b1, "R7 read strobe", 32'(mem_rd_en), 32'd1);
      chk(mem_addr == wa, "R1 read address", 32'(mem_addr), 32'(wa));
      for (int i = 0; i <= lat; i++) begin
         if (poke) begin
            req_valid = 1'b1; req_op = ~op; req_addr = addr ^ AW'(8);
         end
         @(negedge clk);
         chk(req_ready == 1'b0 && mem_rd_en == 1'b0, "R9 busy, no extra read",
             {30'd0, req_ready, mem_rd_en}, 32'd0);
      end
      req_valid = 1'b0;
      mem_rvalid = 1'b1; mem_rdata = memv;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = 32'h5A5A_5A5A;
      if (!op[1]) begin
         chk(done == 1'b1, "R8 load done", 32'(done), 32'd1);
         chk(done_data == exp, {op_req(op), " load merge"}, done_data, exp);
         chk(done_dest == dest, "R8 done dest", 32'(done_dest), 32'(dest));
         chk(mem_wr_en == 1'b0, "R8 no write on load", 32'(mem_wr_en), 32'd0);
      end else begin
         chk(mem_wr_en == 1'b1 && done == 1'b0, "R7 write strobe",
             {30'd0, mem_wr_en, done}, 32'd2);
         chk(mem_wdata == exp, {op_req(op), " store merge"}, mem_wdata, exp);
         chk(mem_addr == wa, "R1 write address", 32'(mem_addr), 32'(wa));
         mem_w[addr[7:2]] = mem_wdata;
         @(negedge clk);
         chk(done == 1'b1 && mem_wr_en == 1'b0, "R7 done after write",
             {30'd0, done, mem_wr_en}, 32'd2);
      end
      @(negedge clk);
      chk(done == 1'b0 && req_ready == 1'b1, "R8 single done pulse",
          {30'd0, done, req_ready}, 32'd1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   initial begin : stim
      logic [31:0] pats [3];
      pats[0] = 32'h1122_3344;
      pats[1] = 32'hF0E1_D2C3;
      pats[2] = 32'h8000_00FF;
      for (int i = 0; i < 64; i++) mem_w[i] = 32'hA0B0_C0D0 ^ (32'(i) * 32'h0103_0507);
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(req_ready == 1'b1 && mem_rd_en == 1'b0 && mem_wr_en == 1'b0 && done == 1'b0,
          "R10 reset outputs", {28'd0, req_ready, mem_rd_en, mem_wr_en, done}, 32'h8);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && done == 1'b0, "R10 idle after reset",
          {30'd0, req_ready, done}, 32'd2);

      // R2 R3 R4 R5 R1: every op, every offset, several operands and latencies
      for (int p = 0; p < 3; p++) begin
         for (int o = 0; o < 4; o++) begin
            for (int k = 0; k < 4; k++) begin
               run_op(2'(o), AW'((p*16 + o*4 + k) * 1 + (p*16 + o*4) * 3), pats[p],
                      RIW'(o*4 + k + 1), 1'b0, '0, '0, (o + k + p) % 3, 1'b0);
            end
         end
      end

      // R6 forwarding cases
      run_op(2'b00, 8'h41, 32'h0102_0304, 5'd7, 1'b1, 5'd7, 32'hCAFE_F00D, 0, 1'b0);
      run_op(2'b01, 8'h46, 32'h0102_0304, 5'd9, 1'b1, 5'd9, 32'h7766_5544, 1, 1'b0);
      run_op(2'b00, 8'h42, 32'h0102_0304, 5'd7, 1'b1, 5'd8, 32'hCAFE_F00D, 0, 1'b0);
      run_op(2'b01, 8'h4B, 32'h0102_0304, 5'd3, 1'b0, 5'd3, 32'hCAFE_F00D, 0, 1'b0);
      run_op(2'b11, 8'h4D, 32'hAABB_CCDD, 5'd4, 1'b1, 5'd4, 32'h1234_5678, 0, 1'b0);

      // R9 request offered while busy is ignored
      run_op(2'b10, 8'h51, 32'h99AA_BBCC, 5'd2, 1'b0, '0, '0, 2, 1'b1);
      run_op(2'b01, 8'h62, 32'h0F0F_0F0F, 5'd6, 1'b0, '0, '0, 1, 1'b1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(mem_rd_en == 1'b0 && done == 1'b0, "R9 nothing after poke",
             {30'd0, mem_rd_en, done}, 32'd0);
      end

      // R4 R5 stored word visible to a later full-word load
      run_op(2'b11, 8'hA2, 32'h1357_9BDF, 5'd1, 1'b0, '0, '0, 0, 1'b0);
      run_op(2'b01, 8'hA0, 32'h0, 5'd1, 1'b0, '0, '0, 0, 1'b0);
      chk(done_data == mem_w[8'hA0 >> 2], "R5 readback", done_data, mem_w[8'hA0 >> 2]);

      report();
      $finish;
   end
endmodule